// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns a single burst request into the stream of column addresses that a synchronous DRAM controller presents on successive cycles. A start strobe captures the first column, the burst-length code, the wrap ordering and the read/write direction. From the next cycle on, the block emits one column per cycle with a valid flag. It raises a last flag on the final beat of a burst that has a fixed length.

Two orderings are supported inside an aligned block of 2, 4 or 8 columns: a linear count that wraps, and a pattern that flips the low address bits. A page-length setting walks every column of the row and wraps at the end of the row. That burst runs until a stop request or a new start ends it. When the write-single control is set, every write becomes a single-beat access, while reads keep the programmed length. A start strobe is accepted on any cycle and replaces whatever burst is running.

Top module: `sdr_burst_colseq`

## Requirements
- R1: After reset, and until the first start strobe, valid_o and last_o are 0.
- R2: A start strobe sampled on a clock edge makes the next cycle show beat 0 with col_o equal to the captured start column and valid_o at 1. A start that arrives during a burst abandons the old burst at once.
- R3: With ordering bit 0 and length code 001, 010 or 011 (2, 4 or 8 beats), beat k gives the column whose upper bits match the start column. Its low log2(length) bits equal the start column's low bits plus k, modulo the length.
- R4: With ordering bit 1 and length code 001, 010 or 011, beat k gives the start column with its low log2(length) bits XORed with k. The upper bits do not change.
- R5: Length code 111 selects a page burst. Beat k gives (start + k) mod 2^COL_W, so the column wraps from the top of the row to 0. The ordering bit has no effect, last_o never goes high, and the burst ends only on a stop or a new start.
- R6: Length code 000 gives a one-beat burst with last_o high on that beat. The unused codes 100, 101 and 110 behave the same way.
- R7: When wr_single_i is 1 at the start strobe, a write (is_write_i = 1) is one beat long whatever its length code. A read keeps its programmed length.
- R8: last_o is high only on the final beat of a fixed-length burst. Without a new start, valid_o is 0 in the cycle after that beat.
- R9: stop_i sampled during a burst, with no start on the same edge, makes valid_o 0 from the next cycle. When start and stop arrive together, the start wins.
- R10: stop_i while no burst is running has no effect: valid_o stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a burst with the request fields below |
| is_write_i | input | 1 | 1 = write burst, 0 = read burst |
| stop_i | input | 1 | End the current burst after the beat shown this cycle |
| start_col_i | input | COL_W | First column of the burst |
| blen_code_i | input | 3 | Burst length code (000=1, 001=2, 010=4, 011=8, 111=page) |
| interleave_i | input | 1 | Wrap ordering: 0 linear, 1 XOR pattern |
| wr_single_i | input | 1 | Force writes to a single beat |
| col_o | output | COL_W | Column address for the current beat |
| valid_o | output | 1 | col_o carries a beat |
| last_o | output | 1 | Current beat is the final one of a fixed-length burst |

## Verification
The in-RTL assertions check the following on every cycle: a burst arms after a start, a stop or a final beat ends it, last never shows without valid, and a page burst never flags last. They also check that the upper column bits hold steady inside a short burst and that a write-single start yields an immediate last beat. The actual column values need the bench's reference model. The same holds for the wrap points of both orderings, the page wrap at the top of the row, the reserved length codes, and the read bursts that write-single must leave untouched. The bench compares all of these beat by beat under directed and random request streams.

// File: rtl/sdr_burst_pkg.sv
package sdr_burst_pkg;

    typedef enum logic [2:0] {
        BL_ONE   = 3'b000,
        BL_TWO   = 3'b001,
        BL_FOUR  = 3'b010,
        BL_EIGHT = 3'b011,
        BL_PAGE  = 3'b111
    } blen_code_e;

    // Burst geometry: page flag, else log2 of beat count (0..3)
    typedef struct packed {
        logic       full;
        logic [1:0] lg;
    } burst_shape_t;

    function automatic burst_shape_t shape_of(input logic [2:0] code,
                                              input logic       force_one);
        burst_shape_t s;
        s = '0;
        if (!force_one) begin
            case (code)
                BL_TWO:   s.lg = 2'd1;
                BL_FOUR:  s.lg = 2'd2;
                BL_EIGHT: s.lg = 2'd3;
                BL_PAGE:  s.full = 1'b1;
                default:  s.lg = 2'd0;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/burst_shape_dec.sv
module burst_shape_dec
    import sdr_burst_pkg::*;
(
    input  logic [2:0]   code_i,
    input  logic         is_write_i,
    input  logic         wr_single_i,
    output burst_shape_t shape_o
);
    logic force_one;

    always_comb begin
        force_one = is_write_i & wr_single_i;
        shape_o   = shape_of(code_i, force_one);
    end
endmodule

// File: rtl/burst_beat_ctrl.sv
module burst_beat_ctrl
    import sdr_burst_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic             inter_i,
    input  burst_shape_t     shape_i,
    output logic             active_o,
    output logic             last_o,
    output logic [COL_W-1:0] base_o,
    output logic [COL_W-1:0] beat_o,
    output logic             inter_o,
    output burst_shape_t     shape_o
);
    localparam logic [COL_W-1:0] ONE = COL_W'(1);

    logic [COL_W-1:0] beat_lim;

    always_comb begin
        beat_lim = (ONE << shape_o.lg) - ONE;
        last_o   = active_o && !shape_o.full && (beat_o == beat_lim);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_o <= 1'b0;
            base_o   <= '0;
            beat_o   <= '0;
            inter_o  <= 1'b0;
            shape_o  <= '0;
        end else if (start_i) begin
            active_o <= 1'b1;
            base_o   <= start_col_i;
            beat_o   <= '0;
            inter_o  <= inter_i;
            shape_o  <= shape_i;
        end else if (active_o) begin
            if (stop_i || last_o) begin
                active_o <= 1'b0;
            end else begin
                beat_o <= beat_o + ONE;
            end
        end
    end

    // R8
    last_needs_active_chk: assert property (@(posedge clk) disable iff (rst)
        last_o |-> active_o);

    // R2
    start_arms_chk: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (active_o && beat_o == '0));

    // R9
    stop_halts_chk: assert property (@(posedge clk) disable iff (rst)
        (active_o && stop_i && !start_i) |=> !active_o);

    // R8
    end_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        (last_o && !start_i) |=> !active_o);

    // R5
    page_never_last_chk: assert property (@(posedge clk) disable iff (rst)
        (active_o && shape_o.full) |-> !last_o);

    // R10
    idle_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (!active_o && !start_i) |=> !active_o);
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import sdr_burst_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] beat_i,
    input  logic             inter_i,
    input  burst_shape_t     shape_i,
    output logic [COL_W-1:0] col_o
);
    localparam logic [COL_W-1:0] ONE = COL_W'(1);

    logic [COL_W-1:0] wrap_mask;
    logic [COL_W-1:0] linear_sum;

    always_comb begin
        wrap_mask  = (ONE << shape_i.lg) - ONE;
        linear_sum = base_i + beat_i;
        if (shape_i.full) begin
            col_o = linear_sum;
        end else if (inter_i) begin
            col_o = base_i ^ (beat_i & wrap_mask);
        end else begin
            col_o = (base_i & ~wrap_mask) | (linear_sum & wrap_mask);
        end
    end
endmodule

// File: rtl/sdr_burst_colseq.sv
module sdr_burst_colseq
    import sdr_burst_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             is_write_i,
    input  logic             stop_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [2:0]       blen_code_i,
    input  logic             interleave_i,
    input  logic             wr_single_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             last_o
);
    localparam int HI_LO = 3;

    burst_shape_t     shape_req;
    burst_shape_t     shape_q;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] beat_q;
    logic             inter_q;

    burst_shape_dec u_dec (
        .code_i      (blen_code_i),
        .is_write_i  (is_write_i),
        .wr_single_i (wr_single_i),
        .shape_o     (shape_req)
    );

    burst_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .stop_i      (stop_i),
        .start_col_i (start_col_i),
        .inter_i     (interleave_i),
        .shape_i     (shape_req),
        .active_o    (valid_o),
        .last_o      (last_o),
        .base_o      (base_q),
        .beat_o      (beat_q),
        .inter_o     (inter_q),
        .shape_o     (shape_q)
    );

    burst_col_gen #(.COL_W(COL_W)) u_col (
        .base_i  (base_q),
        .beat_i  (beat_q),
        .inter_i (inter_q),
        .shape_i (shape_q),
        .col_o   (col_o)
    );

    // R7
    wr_single_one_beat_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && is_write_i && wr_single_i) |=> (valid_o && last_o));

    // R3 R4
    block_bits_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !last_o && !start_i && !stop_i && !shape_q.full)
        |=> (col_o[COL_W-1:HI_LO] == $past(col_o[COL_W-1:HI_LO])));

    // R2
    first_beat_col_chk: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (col_o == $past(start_col_i)));
endmodule

// File: tb/sdr_burst_colseq_test.sv
`timescale 1ns/1ps
module sdr_burst_colseq_test;
    localparam int COL_W = 9;
    localparam int NCOL  = 1 << COL_W;

    logic             clk = 1'b0;
    logic             rst;
    logic             start_i, is_write_i, stop_i, interleave_i, wr_single_i;
    logic [COL_W-1:0] start_col_i;
    logic [2:0]       blen_code_i;
    logic [COL_W-1:0] col_o;
    logic             valid_o, last_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;
    string tag = "R1";

    // reference model state
    bit m_act;
    int m_base, m_k, m_len, m_int;

    always #2 clk = ~clk;

    sdr_burst_colseq #(.COL_W(COL_W)) uut (
        .clk(clk), .rst(rst), .start_i(start_i), .is_write_i(is_write_i),
        .stop_i(stop_i), .start_col_i(start_col_i), .blen_code_i(blen_code_i),
        .interleave_i(interleave_i), .wr_single_i(wr_single_i),
        .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
    );

    function automatic int len_of(input int code, input bit wr, input bit ws);
        if (wr && ws) return 1;
        case (code)
            1: return 2;
            2: return 4;
            3: return 8;
            7: return 0;
            default: return 1;
        endcase
    endfunction

    function automatic int exp_col(input int base, input int k, input int len, input int il);
        int blk, off;
        if (len == 0) return (base + k) % NCOL;
        blk = (base / len) * len;
        off = base % len;
        if (il != 0) return blk + (off ^ k);
        return blk + ((off + k) % len);
    endfunction

    task automatic check_now();
        bit e_last;
        int e_col;
        e_last = m_act && (m_len != 0) && (m_k == m_len - 1);
        e_col  = exp_col(m_base, m_k, m_len, m_int);
        n_chk++;
        if (valid_o !== m_act) begin
            n_bad++;
            $display("FAIL %s valid: actual %0b expected %0b", tag, valid_o, m_act);
        end else if (m_act && (int'(col_o) != e_col || last_o !== e_last)) begin
            n_bad++;
            $display("FAIL %s col/last: actual %0d/%0b expected %0d/%0b",
                     tag, col_o, last_o, e_col, e_last);
        end else if (!m_act && last_o !== 1'b0) begin
            n_bad++;
            $display("FAIL %s last while idle: actual %0b expected 0", tag, last_o);
        end
    endtask

    // one cycle: check current outputs, drive next inputs, advance model
    task automatic step(input bit st, input bit sp, input int col, input int code,
                        input bit wr, input bit il, input bit ws);
        @(negedge clk);
        check_now();
        start_i = st; stop_i = sp; start_col_i = COL_W'(col);
        blen_code_i = 3'(code); is_write_i = wr; interleave_i = il; wr_single_i = ws;
        if (st) begin
            m_act = 1; m_base = col; m_k = 0; m_len = len_of(code, wr, ws);
            m_int = (len_of(code, wr, ws) == 0) ? 0 : int'(il);
        end else if (m_act) begin
            if (sp || (m_len != 0 && m_k == m_len - 1)) m_act = 0;
            else m_k = (m_k + 1) % NCOL;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        rst = 1; start_i = 0; stop_i = 0; start_col_i = '0; blen_code_i = '0;
        is_write_i = 0; interleave_i = 0; wr_single_i = 0;
        m_act = 0; m_base = 0; m_k = 0; m_len = 1; m_int = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        tag = "R1"; idle(3);
        tag = "R10"; step(0, 1, 5, 2, 0, 0, 0); idle(2);
        tag = "R3"; step(1, 0, 'h105, 2, 0, 0, 0); idle(5);
        step(1, 0, 'h0FE, 3, 0, 0, 0); idle(9);
        tag = "R4"; step(1, 0, 'h0B3, 3, 0, 1, 0); idle(9);
        step(1, 0, 'h041, 1, 1, 1, 0); idle(3);
        tag = "R5"; step(1, 0, 510, 7, 0, 1, 0); idle(12);
        tag = "R9"; step(0, 1, 0, 0, 0, 0, 0); idle(3);
        tag = "R6"; step(1, 0, 77, 0, 0, 0, 0); idle(2);
        step(1, 0, 78, 5, 0, 0, 0); idle(2);
        tag = "R7"; step(1, 0, 33, 3, 1, 0, 1); idle(3);
        step(1, 0, 34, 3, 0, 0, 1); idle(9);
        tag = "R2"; step(1, 0, 200, 3, 0, 0, 0); idle(2);
        step(1, 0, 300, 2, 0, 1, 0); idle(5);
        tag = "R9"; step(1, 0, 400, 3, 0, 0, 0); idle(1);
        step(1, 1, 12, 2, 0, 0, 0); idle(5);
        tag = "R8"; step(1, 0, 9, 1, 0, 0, 0); idle(3);
        tag = "R3 R4 R5 R7 random";
        void'($urandom(32'h5eed1234));
        for (int i = 0; i < 4000; i++) begin
            int cs;
            cs = $urandom % 5;
            step(($urandom % 5) == 0, ($urandom % 12) == 0, $urandom % NCOL,
                 (cs == 4) ? 7 : (($urandom % 8 == 0) ? 4 + $urandom % 3 : cs),
                 $urandom % 2, $urandom % 2, ($urandom % 3) == 0);
        end
        idle(2);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule